// File: doc/BRIEF.md
# Masked-Address GPIO Bank with Interrupts

This block is one bank of eight general-purpose I/O lines on a byte-wide register bus. Each line can be an input or an output. Each line can also be handed to another on-chip function, which then drives the line's output value and output enable. For the data and direction registers, address bits act as a write and read mask. Software can therefore change one line, or any set of lines, with a single write and never needs a read-modify-write.

Every line can also raise an interrupt. A line can trigger on a high or low level, on a rising or falling edge, or on both edges. Pin inputs are synchronised before any detection. Edge events are held in a latch until software clears them. Software sees a raw status and a masked status. The bank drives a single interrupt line that is high when any enabled status bit is set. The bank decodes the low twelve address bits, and bits [1:0] are ignored.

Top module: `gpio_bank`

## Requirements
- R1: A write whose address bits [11:10] are 00 stores wdata bit n in output register bit n only when address bit n+2 is 1; output bits whose address bit is 0 keep their value.
- R2: A read whose address bits [11:10] are 00 returns, for each line n whose address bit n+2 is 1, the output register bit if the line is an output, else the synchronised pin. Unselected bits read 0.
- R3: The direction register is reached with address bits [11:10] = 10 and the same per-bit address mask. Bit value 1 makes the line an output. pin_oe_o follows the register for lines without alternate function.
- R4: Alternate-function register at 0x420: a 1 in bit n routes alt_out_i[n] and alt_oe_i[n] to pin_o[n] and pin_oe_o[n].
- R5: pin_i passes through two flops. A pin change becomes visible in a data read after the second rising clock edge, and not after the first.
- R6: Sense register at 0x404, where 1 selects level mode. In level mode the raw status bit equals the synchronised pin when the event bit is 1 and its inverse when the event bit is 0. Writes to 0x41C cannot clear it.
- R7: Event register at 0x40C, in edge mode with the both-edges bit 0: value 1 latches a rising edge and value 0 latches a falling edge. The latched bit stays set until it is cleared.
- R8: Both-edges register at 0x408: a 1 makes the line latch on either edge, whatever its event bit holds.
- R9: Writing to 0x41C clears the latched edge bits written as 1. Bits written as 0 are unchanged. An edge detected in the same cycle as the clear leaves the bit set.
- R10: Enable register at 0x410. 0x414 reads the raw status and 0x418 reads the raw status ANDed with the enables. irq_o is the OR of the masked bits.
- R11: After reset all registers are 0: pin_o, pin_oe_o and irq_o are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| alt_out_i | input | 8 | Alternate-function output values |
| alt_oe_i | input | 8 | Alternate-function output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a masked data write changes only the selected output bits. They also check that a latched edge bit sets only after a change of the synchronised pin, that it falls only because of a clear bit or level mode, and that it stays zero in level mode. A further check is that irq_o stays low while nothing is enabled or pending. The bench's scenarios alone show the two-flop delay and the polarity choices of level, rising, falling and both-edge modes. They also show the clear colliding with an edge in the same cycle, the routing of the alternate function, and the masked read values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    RGN_DATA = 2'b00,
    RGN_CTRL = 2'b01,
    RGN_DIR  = 2'b10,
    RGN_NONE = 2'b11
  } region_e;

  // word index inside the control region (byte offset >> 2)
  localparam int unsigned IDX_SENSE = 1;
  localparam int unsigned IDX_BOTH  = 2;
  localparam int unsigned IDX_EVENT = 3;
  localparam int unsigned IDX_EN    = 4;
  localparam int unsigned IDX_RAW   = 5;
  localparam int unsigned IDX_MSK   = 6;
  localparam int unsigned IDX_CLR   = 7;
  localparam int unsigned IDX_ALT   = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] lat_o
);
  logic [NUM_PINS-1:0] prev_q, lat_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= sync_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, lvl;
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];
    assign hit[i] = both_i[i] ? (rise | fall) : (event_i[i] ? rise : fall);
    assign lvl = event_i[i] ? sync_i[i] : ~sync_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q[i] <= 1'b0;
      else if (sense_i[i]) lat_q[i] <= 1'b0;
      else if (hit[i]) lat_q[i] <= 1'b1;   // set wins over clear
      else if (clr_i[i]) lat_q[i] <= 1'b0;
    end

    assign raw_o[i] = sense_i[i] ? lvl : lat_q[i];
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  input  logic [NUM_PINS-1:0] raw_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] event_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] alt_o,
  output logic [NUM_PINS-1:0] clr_o
);
  localparam int unsigned MASK_MSB = NUM_PINS + 1;
  localparam int unsigned IDX_W    = ADDR_W - 4;

  logic [NUM_PINS-1:0] mask, dout_q, dir_q, sense_q, both_q, event_q, en_q, alt_q;
  logic [IDX_W-1:0]    idx;
  region_e             region;
  logic                wr_en;

  assign mask  = addr_i[MASK_MSB:2];
  assign idx   = addr_i[ADDR_W-3:2];
  assign wr_en = sel_i & wr_i;
  assign region = region_e'(addr_i[ADDR_W-1:ADDR_W-2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0; dir_q <= '0; sense_q <= '0; both_q <= '0;
      event_q <= '0; en_q <= '0; alt_q <= '0;
    end else if (wr_en) begin
      unique case (region)
        RGN_DATA: dout_q <= (dout_q & ~mask) | (wdata_i & mask);
        RGN_DIR:  dir_q  <= (dir_q & ~mask) | (wdata_i & mask);
        RGN_CTRL: begin
          if (idx == IDX_W'(IDX_SENSE)) sense_q <= wdata_i;
          if (idx == IDX_W'(IDX_BOTH))  both_q  <= wdata_i;
          if (idx == IDX_W'(IDX_EVENT)) event_q <= wdata_i;
          if (idx == IDX_W'(IDX_EN))    en_q    <= wdata_i;
          if (idx == IDX_W'(IDX_ALT))   alt_q   <= wdata_i;
        end
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && region == RGN_CTRL && idx == IDX_W'(IDX_CLR)) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    unique case (region)
      RGN_DATA: rdata_o = ((dir_q & dout_q) | (~dir_q & pin_sync_i)) & mask;
      RGN_DIR:  rdata_o = dir_q & mask;
      RGN_CTRL: begin
        if (idx == IDX_W'(IDX_SENSE)) rdata_o = sense_q;
        if (idx == IDX_W'(IDX_BOTH))  rdata_o = both_q;
        if (idx == IDX_W'(IDX_EVENT)) rdata_o = event_q;
        if (idx == IDX_W'(IDX_EN))    rdata_o = en_q;
        if (idx == IDX_W'(IDX_RAW))   rdata_o = raw_i;
        if (idx == IDX_W'(IDX_MSK))   rdata_o = raw_i & en_q;
        if (idx == IDX_W'(IDX_ALT))   rdata_o = alt_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign dout_o  = dout_q;
  assign dir_o   = dir_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign event_o = event_q;
  assign en_o    = en_q;
  assign alt_o   = alt_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_PINS-1:0] alt_oe_i,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_sync, raw, lat, clr;
  logic [NUM_PINS-1:0] dout, dir, sense, both, evt, en, alt;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i,
    .pin_sync_i(pin_sync), .raw_i(raw), .rdata_o,
    .dout_o(dout), .dir_o(dir), .sense_o(sense), .both_o(both),
    .event_o(evt), .en_o(en), .alt_o(alt), .clr_o(clr)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i, .rst_ni, .sync_i(pin_sync), .sense_i(sense), .both_i(both),
    .event_i(evt), .clr_i(clr), .raw_o(raw), .lat_o(lat)
  );

  assign pin_o    = (alt & alt_out_i) | (~alt & dout);
  assign pin_oe_o = (alt & alt_oe_i)  | (~alt & dir);
  assign irq_o    = |(raw & en);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sel_i,
  input logic                wr_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] dout_i,
  input logic [NUM_PINS-1:0] sync_i,
  input logic [NUM_PINS-1:0] lat_i,
  input logic [NUM_PINS-1:0] sense_i,
  input logic [NUM_PINS-1:0] raw_i,
  input logic [NUM_PINS-1:0] en_i,
  input logic                irq_i
);
  logic                data_wr;
  logic [NUM_PINS-1:0] amask, clr_bits;

  assign amask    = addr_i[NUM_PINS+1:2];
  assign data_wr  = sel_i && wr_i && (addr_i[ADDR_W-1:ADDR_W-2] == 2'b00);
  assign clr_bits = (sel_i && wr_i && addr_i[ADDR_W-1:ADDR_W-2] == 2'b01
                     && addr_i[ADDR_W-3:2] == (ADDR_W-4)'(7)) ? wdata_i : '0;

  a_r1_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> ((dout_i & $past(amask)) == ($past(wdata_i) & $past(amask))));

  a_r1_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> ((dout_i & ~$past(amask)) == ($past(dout_i) & ~$past(amask))));

  a_r6_level_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lat_i & $past(sense_i)) == '0));

  a_r7_latch_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lat_i & ~$past(lat_i)) != '0) |->
      ((lat_i & ~$past(lat_i) & ~($past(sync_i) ^ $past(sync_i, 2))) == '0));

  a_r9_zero_bits_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(lat_i) & ~lat_i & ~$past(clr_bits) & ~$past(sense_i)) == '0));

  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_i);

  a_r10_irq_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == '0) |-> !irq_i);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .dout_i(dout), .sync_i(pin_sync), .lat_i(lat),
  .sense_i(sense), .raw_i(raw), .en_i(en), .irq_i(irq_o)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, pin = '0, alt_out = '0, alt_oe = '0;
  logic [7:0] rdata, pin_o, pin_oe;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .alt_out_i(alt_out), .alt_oe_i(alt_oe), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] m_dout, m_dir, m_sense, m_both, m_ev, m_en, m_alt, m_lat, m_s1, m_s2, m_prev;

  function automatic logic [7:0] m_raw();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_sense[i] ? (m_ev[i] ? m_s2[i] : !m_s2[i]) : m_lat[i];
    return r;
  endfunction

  function automatic logic [7:0] m_read(logic [11:0] a);
    logic [7:0] mk;
    mk = a[9:2];
    case (a[11:10])
      2'd0: return ((m_dir & m_dout) | (~m_dir & m_s2)) & mk;
      2'd2: return m_dir & mk;
      2'd1: case (a[9:0])
        10'h004: return m_sense;
        10'h008: return m_both;
        10'h00C: return m_ev;
        10'h010: return m_en;
        10'h014: return m_raw();
        10'h018: return m_raw() & m_en;
        10'h020: return m_alt;
        default: return 8'h00;
      endcase
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dout = 0; m_dir = 0; m_sense = 0; m_both = 0; m_ev = 0; m_en = 0;
      m_alt = 0; m_lat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      logic [7:0] clr, nl;
      clr = (sel && wr && addr == 12'h41C) ? wdata : 8'h00;
      for (int i = 0; i < 8; i++) begin
        bit r, f, h;
        r = m_s2[i] && !m_prev[i];
        f = !m_s2[i] && m_prev[i];
        h = m_both[i] ? (r || f) : (m_ev[i] ? r : f);
        if (m_sense[i]) nl[i] = 0;
        else if (h) nl[i] = 1;
        else if (clr[i]) nl[i] = 0;
        else nl[i] = m_lat[i];
      end
      m_lat = nl;
      if (sel && wr) begin
        if (addr[11:10] == 2'd0) m_dout = (m_dout & ~addr[9:2]) | (wdata & addr[9:2]);
        if (addr[11:10] == 2'd2) m_dir  = (m_dir & ~addr[9:2]) | (wdata & addr[9:2]);
        if (addr == 12'h404) m_sense = wdata;
        if (addr == 12'h408) m_both = wdata;
        if (addr == 12'h40C) m_ev = wdata;
        if (addr == 12'h410) m_en = wdata;
        if (addr == 12'h420) m_alt = wdata;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #3;
    if (rst_ni && !done) begin
      chk("R1", "pin_o vs model", pin_o, (m_alt & alt_out) | (~m_alt & m_dout));
      chk("R3", "pin_oe_o vs model", pin_oe, (m_alt & alt_oe) | (~m_alt & m_dir));
      chk("R10", "irq_o vs model", {7'b0, irq}, {7'b0, |(m_raw() & m_en)});
      chk("R2", "rdata_o vs model", rdata, m_read(addr));
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, logic [7:0] exp, string req);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #2 chk(req, $sformatf("read %h", a), rdata, exp);
  endtask

  task automatic set_pin(logic [7:0] v);
    @(negedge clk); pin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R11", "pin_o at reset", pin_o, 8'h00);
    chk("R11", "pin_oe_o at reset", pin_oe, 8'h00);
    chk("R11", "irq_o at reset", {7'b0, irq}, 8'h00);
    rst_ni = 1;
    bus_rd(12'h3FC, 8'h00, "R11");
    bus_rd(12'h410, 8'h00, "R11");

    // R3 direction, masked to the low four lines
    bus_wr(12'h83C, 8'hFF);
    bus_rd(12'hBFC, 8'h0F, "R3");
    chk("R3", "pin_oe_o", pin_oe, 8'h0F);
    // R1 masked data writes
    bus_wr(12'h3FC, 8'hA5);
    chk("R1", "pin_o full write", pin_o, 8'hA5);
    bus_wr(12'h00C, 8'h00);
    chk("R1", "pin_o masked write", pin_o, 8'hA4);
    // R2 masked reads mixing outputs and inputs
    set_pin(8'hF0);
    bus_rd(12'h3FC, 8'hF4, "R2");
    bus_rd(12'h0C0, 8'h30, "R2");
    // R5 two-flop latency
    @(negedge clk); pin = 8'h00; addr = 12'h3FC; sel = 0;
    @(negedge clk); #2 chk("R5", "after one edge", rdata, 8'hF4);
    @(negedge clk); #2 chk("R5", "after two edges", rdata, 8'h04);
    // R4 alternate function
    alt_out = 8'hFF; alt_oe = 8'h00;
    bus_wr(12'h420, 8'h81);
    chk("R4", "pin_o alt", pin_o, 8'hA5);
    chk("R4", "pin_oe_o alt", pin_oe, 8'h0E);
    bus_wr(12'h420, 8'h00);
    // R6 level high on line 0
    bus_wr(12'h404, 8'h01);
    bus_wr(12'h40C, 8'h01);
    bus_wr(12'h410, 8'h01);
    chk("R6", "irq_o pin low", {7'b0, irq}, 8'h00);
    set_pin(8'h01);
    bus_rd(12'h414, 8'hF1, "R6");
    bus_wr(12'h41C, 8'hFF);
    bus_rd(12'h414, 8'h01, "R6");
    bus_rd(12'h418, 8'h01, "R10");
    chk("R10", "irq_o level", {7'b0, irq}, 8'h01);
    set_pin(8'h00);
    bus_rd(12'h414, 8'h00, "R6");
    // R7 rising edge on line 1
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h40C, 8'h02);
    bus_wr(12'h410, 8'h02);
    set_pin(8'h02);
    bus_rd(12'h414, 8'h02, "R7");
    chk("R10", "irq_o edge", {7'b0, irq}, 8'h01);
    set_pin(8'h00);
    bus_rd(12'h414, 8'h02, "R7");
    bus_wr(12'h41C, 8'h00);
    bus_rd(12'h414, 8'h02, "R9");
    bus_wr(12'h41C, 8'h02);
    bus_rd(12'h414, 8'h00, "R9");
    chk("R10", "irq_o cleared", {7'b0, irq}, 8'h00);
    // R8 both edges on line 2
    bus_wr(12'h408, 8'h04);
    set_pin(8'h04);
    bus_rd(12'h414, 8'h04, "R8");
    bus_rd(12'h418, 8'h00, "R10");
    chk("R10", "irq_o not enabled", {7'b0, irq}, 8'h00);
    bus_wr(12'h41C, 8'h04);
    set_pin(8'h00);
    bus_rd(12'h414, 8'h04, "R8");
    bus_wr(12'h41C, 8'h04);
    // R9 clear colliding with a falling edge on line 3
    set_pin(8'h08);
    bus_rd(12'h414, 8'h00, "R7");
    @(negedge clk); pin = 8'h00; sel = 0;
    @(negedge clk);
    @(negedge clk); sel = 1; wr = 1; addr = 12'h41C; wdata = 8'h08;
    @(negedge clk); sel = 0; wr = 0;
    bus_rd(12'h414, 8'h08, "R9");
    bus_wr(12'h41C, 8'h08);
    bus_rd(12'h414, 8'h00, "R9");
    repeat (4) @(negedge clk);
    done = 1;
    summary();
  end
endmodule